// File: doc/BRIEF.md
# Register-Bound Instruction Pointer Processor

A compact multi-cycle processor with six 32-bit general registers and sixteen operations. No instruction is a jump. A configurable register is tied to the instruction pointer instead. Before every instruction the pointer is copied into that register. After the instruction, the register's value becomes the new pointer, and one is added unconditionally. An ordinary move therefore acts as an absolute jump, and an addition acts as a relative jump.

The program is written word by word into an on-chip store of up to 64 instructions. A configuration write sets the bound register and the program length. A start pulse clears the registers, presets register 0 with a seed value and sets the pointer to zero. The block then steps through fetch, operand read, result write and pointer advance. It stops when the pointer falls outside the program. All six registers and a saturating count of executed instructions stay visible at the ports.

Top module: `ipreg_cpu`

## Requirements
- R1: After reset, `halted` is low, all six registers read zero and `steps` is zero. No instruction runs until `start` is pulsed, even when a program is already loaded.
- R2: `start` pulsed while idle or halted clears all registers, loads register 0 from `seed_r0`, sets the pointer to 0, zeroes `steps` and drops `halted`.
- R3: Before each instruction the bound register receives the pointer value. After it, the pointer becomes the bound register's value plus one. Example: with register 0 bound and the seven-word sample program, exactly five instructions run and the registers finish as [6,5,6,0,0,9].
- R4: The block halts when the pointer is not below the program length. With a length of 0 it halts without executing anything. `halted` then stays high until the next start.
- R5: While halted, the registers and `steps` do not change.
- R6: Instruction word layout is opcode [51:48], A [47:32], B [31:16], C [15:0]. The result goes to the register named by C. Register operands use the low 3 bits of their field. Indices 6 and 7 read as zero, and writes to them are dropped. Opcodes are: 0 add reg, 1 add imm, 2 mul reg, 3 mul imm, 4 and reg, 5 and imm, 6 or reg, 7 or imm, 8 copy reg A, 9 load literal A, 10 gt imm/reg, 11 gt reg/imm, 12 gt reg/reg, 13 eq imm/reg, 14 eq reg/imm, 15 eq reg/reg.
- R7: Add and multiply wrap modulo 2^32. Multiply keeps the low 32 bits of the product.
- R8: The AND and OR operations combine A's register value bitwise with a register or a zero-extended literal B.
- R9: The copy and load-literal operations ignore B.
- R10: Comparisons are unsigned and write 1 when true and 0 when false.
- R11: `steps` counts each executed instruction and saturates at its all-ones value.
- R12: A `start` pulse while a program is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 6 | Program store write address |
| prog_word | input | 52 | Instruction word to store |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bind | input | 3 | Index of the register tied to the pointer |
| cfg_len | input | 7 | Program length (halt bound), clamped to 64 |
| seed_r0 | input | 32 | Value loaded into register 0 at start |
| start | input | 1 | Start strobe |
| halted | output | 1 | High once the pointer has left the program |
| regs_flat | output | 192 | Register i at bits [32*i+31:32*i] |
| steps | output | STEP_W | Saturating executed-instruction count |

## Verification
The bench builds the block with STEP_W set to 4, so the executed-instruction count saturates at 15. A short counting loop of twenty instructions then reaches that ceiling, which a 32-bit counter never would. The data width and store depth keep their defaults. The wrap-around of add and multiply and the unsigned comparisons are therefore tested at full 32-bit width.

// File: rtl/ipreg_cpu_pkg.sv
package ipreg_cpu_pkg;

    localparam int OPC_W     = 4;
    localparam int FLD_W     = 16;
    localparam int NUM_REGS  = 6;
    localparam int REG_IDX_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD_RR = 4'd0,  OP_ADD_RI = 4'd1,
        OP_MUL_RR = 4'd2,  OP_MUL_RI = 4'd3,
        OP_AND_RR = 4'd4,  OP_AND_RI = 4'd5,
        OP_OR_RR  = 4'd6,  OP_OR_RI  = 4'd7,
        OP_MOV_R  = 4'd8,  OP_MOV_I  = 4'd9,
        OP_GT_IR  = 4'd10, OP_GT_RI  = 4'd11, OP_GT_RR = 4'd12,
        OP_EQ_IR  = 4'd13, OP_EQ_RI  = 4'd14, OP_EQ_RR = 4'd15
    } opcode_e;

    typedef struct packed {
        opcode_e          op;
        logic [FLD_W-1:0] a;
        logic [FLD_W-1:0] b;
        logic [FLD_W-1:0] c;
    } instr_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_FETCH, PH_READ, PH_EXEC, PH_STEP, PH_HALT
    } phase_e;

    function automatic logic a_is_reg(opcode_e op);
        return !(op == OP_MOV_I || op == OP_GT_IR || op == OP_EQ_IR);
    endfunction

    function automatic logic b_is_reg(opcode_e op);
        case (op)
            OP_ADD_RR, OP_MUL_RR, OP_AND_RR, OP_OR_RR,
            OP_GT_IR, OP_GT_RR, OP_EQ_IR, OP_EQ_RR: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic is_cmp(opcode_e op);
        return op >= OP_GT_IR;
    endfunction

endpackage

// File: rtl/ipreg_alu.sv
module ipreg_alu
    import ipreg_cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  opcode_e          op,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    output logic [XLEN-1:0]  res
);

    always_comb begin
        unique case (op)
            OP_ADD_RR, OP_ADD_RI:           res = a_val + b_val;
            OP_MUL_RR, OP_MUL_RI:           res = a_val * b_val;
            OP_AND_RR, OP_AND_RI:           res = a_val & b_val;
            OP_OR_RR,  OP_OR_RI:            res = a_val | b_val;
            OP_MOV_R,  OP_MOV_I:            res = a_val;
            OP_GT_IR, OP_GT_RI, OP_GT_RR:   res = XLEN'(a_val > b_val);
            default:                        res = XLEN'(a_val == b_val);
        endcase
    end

endmodule

// File: rtl/ipreg_regfile.sv
module ipreg_regfile
    import ipreg_cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic [XLEN-1:0]            r0_init,
    input  logic                       we,
    input  logic [REG_IDX_W-1:0]       waddr,
    input  logic [XLEN-1:0]            wdata,
    input  logic [REG_IDX_W-1:0]       ra,
    input  logic [REG_IDX_W-1:0]       rb,
    input  logic [REG_IDX_W-1:0]       rbind,
    output logic [XLEN-1:0]            qa,
    output logic [XLEN-1:0]            qb,
    output logic [XLEN-1:0]            qbind,
    output logic [NUM_REGS*XLEN-1:0]   flat
);

    logic [XLEN-1:0] r [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                r[i] <= '0;
            else if (clear)
                r[i] <= (i == 0) ? r0_init : '0;
            else if (we && waddr == REG_IDX_W'(i))
                r[i] <= wdata;
        end
        assign flat[i*XLEN +: XLEN] = r[i];
    end

    always_comb begin
        qa    = '0;
        qb    = '0;
        qbind = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ra    == REG_IDX_W'(i)) qa    = r[i];
            if (rb    == REG_IDX_W'(i)) qb    = r[i];
            if (rbind == REG_IDX_W'(i)) qbind = r[i];
        end
    end

endmodule

// File: rtl/ipreg_cpu.sv
module ipreg_cpu
    import ipreg_cpu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PDEPTH  = 64,
    parameter int STEP_W  = 32,
    localparam int PA_W   = $clog2(PDEPTH),
    localparam int LEN_W  = $clog2(PDEPTH + 1),
    localparam int IW     = $bits(instr_t)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      prog_we,
    input  logic [PA_W-1:0]           prog_addr,
    input  logic [IW-1:0]             prog_word,
    input  logic                      cfg_we,
    input  logic [REG_IDX_W-1:0]      cfg_bind,
    input  logic [LEN_W-1:0]          cfg_len,
    input  logic [XLEN-1:0]           seed_r0,
    input  logic                      start,
    output logic                      halted,
    output logic [NUM_REGS*XLEN-1:0]  regs_flat,
    output logic [STEP_W-1:0]         steps
);

    logic [IW-1:0]          store [PDEPTH];
    phase_e                 phase_q;
    instr_t                 instr_q;
    logic [XLEN-1:0]        ip_q, opa_q, opb_q;
    logic [REG_IDX_W-1:0]   bind_q;
    logic [LEN_W-1:0]       len_q;
    logic [STEP_W-1:0]      steps_q;

    logic                   launch, in_range, rf_we;
    logic [REG_IDX_W-1:0]   rf_waddr;
    logic [XLEN-1:0]        rf_wdata, q_a, q_b, q_bind, alu_res;

    assign launch   = start && (phase_q == PH_IDLE || phase_q == PH_HALT);
    assign in_range = ip_q < XLEN'(len_q);
    assign halted   = (phase_q == PH_HALT);
    assign steps    = steps_q;

    // program store and configuration
    always_ff @(posedge clk) begin
        if (prog_we) store[prog_addr] <= prog_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bind_q <= '0;
            len_q  <= '0;
        end else if (cfg_we) begin
            bind_q <= cfg_bind;
            len_q  <= (cfg_len > LEN_W'(PDEPTH)) ? LEN_W'(PDEPTH) : cfg_len;
        end
    end

    // register file write: pointer copy at fetch, result at exec
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = instr_q.c[REG_IDX_W-1:0];
        rf_wdata = alu_res;
        if (phase_q == PH_FETCH && in_range) begin
            rf_we    = 1'b1;
            rf_waddr = bind_q;
            rf_wdata = ip_q;
        end else if (phase_q == PH_EXEC) begin
            rf_we    = 1'b1;
        end
    end

    ipreg_regfile #(.XLEN(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .r0_init(seed_r0),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra    (instr_q.a[REG_IDX_W-1:0]),
        .rb    (instr_q.b[REG_IDX_W-1:0]),
        .rbind (bind_q),
        .qa    (q_a),
        .qb    (q_b),
        .qbind (q_bind),
        .flat  (regs_flat)
    );

    ipreg_alu #(.XLEN(XLEN)) u_alu (
        .op    (instr_q.op),
        .a_val (opa_q),
        .b_val (opb_q),
        .res   (alu_res)
    );

    // phase sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ip_q    <= '0;
            instr_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            steps_q <= '0;
        end else if (launch) begin
            phase_q <= PH_FETCH;
            ip_q    <= '0;
            steps_q <= '0;
        end else begin
            unique case (phase_q)
                PH_FETCH: begin
                    if (in_range) begin
                        instr_q <= store[ip_q[PA_W-1:0]];
                        phase_q <= PH_READ;
                    end else begin
                        phase_q <= PH_HALT;
                    end
                end
                PH_READ: begin
                    opa_q   <= a_is_reg(instr_q.op) ? q_a : XLEN'(instr_q.a);
                    opb_q   <= b_is_reg(instr_q.op) ? q_b : XLEN'(instr_q.b);
                    phase_q <= PH_EXEC;
                end
                PH_EXEC: phase_q <= PH_STEP;
                PH_STEP: begin
                    ip_q    <= q_bind + XLEN'(1);
                    steps_q <= (steps_q == '1) ? steps_q : steps_q + STEP_W'(1);
                    phase_q <= PH_FETCH;
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

    // assertions
    p_bound_holds_ip_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READ && bind_q < REG_IDX_W'(NUM_REGS)) |-> (q_bind == ip_q));

    p_ip_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STEP) |=> (ip_q == $past(q_bind) + XLEN'(1)));

    p_oob_halts_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH && !in_range && !start) |=> halted);

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> ($stable(regs_flat) && $stable(steps_q)));

    p_launch_clears_r2: assert property (@(posedge clk) disable iff (rst)
        launch |=> (steps_q == '0 && !halted && regs_flat[XLEN-1:0] == $past(seed_r0)));

    p_step_inc_r11: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STEP && steps_q != '1) |=> (steps_q == $past(steps_q) + STEP_W'(1)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        (steps_q == '1 && !launch) |=> (steps_q == '1));

    p_cmp_bool_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && is_cmp(instr_q.op)) |-> (alu_res <= XLEN'(1)));

endmodule

// File: tb/ipreg_cpu_test.sv
`timescale 1ns/1ps
module ipreg_cpu_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_we = 1'b0;
    logic [5:0]   prog_addr = '0;
    logic [51:0]  prog_word = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_bind = '0;
    logic [6:0]   cfg_len = '0;
    logic [31:0]  seed_r0 = '0;
    logic         start = 1'b0;
    logic         halted;
    logic [191:0] regs_flat;
    logic [3:0]   steps;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ipreg_cpu #(.STEP_W(4)) uut (
        .clk(clk), .rst(rst),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_word(prog_word),
        .cfg_we(cfg_we), .cfg_bind(cfg_bind), .cfg_len(cfg_len),
        .seed_r0(seed_r0), .start(start),
        .halted(halted), .regs_flat(regs_flat), .steps(steps)
    );

    // {op, seed, Y, A, B, expected}: word0 loads Y into r2, word1 writes r3
    localparam int NV = 17;
    localparam logic [115:0] VEC [NV] = '{
        {4'd0,  32'hFFFFFFFF, 16'h0002, 16'h0000, 16'h0002, 32'h00000001},
        {4'd1,  32'h00000005, 16'h0000, 16'h0000, 16'h0010, 32'h00000015},
        {4'd2,  32'h12345678, 16'h0100, 16'h0000, 16'h0002, 32'h34567800},
        {4'd3,  32'h80000001, 16'h0000, 16'h0000, 16'h0003, 32'h80000003},
        {4'd4,  32'h0000F0F0, 16'hFF00, 16'h0000, 16'h0002, 32'h0000F000},
        {4'd5,  32'h00001234, 16'h0000, 16'h0000, 16'h0FF0, 32'h00000230},
        {4'd6,  32'hF0000000, 16'h000F, 16'h0000, 16'h0002, 32'hF000000F},
        {4'd7,  32'h00000001, 16'h0000, 16'h0000, 16'h8000, 32'h00008001},
        {4'd8,  32'h00000000, 16'hABCD, 16'h0002, 16'h0007, 32'h0000ABCD},
        {4'd9,  32'hDEADBEEF, 16'h0000, 16'h1234, 16'h0005, 32'h00001234},
        {4'd10, 32'h00000000, 16'h0008, 16'h0009, 16'h0002, 32'h00000001},
        {4'd10, 32'h00000000, 16'h0008, 16'h0008, 16'h0002, 32'h00000000},
        {4'd11, 32'hFFFFFFFF, 16'h0000, 16'h0000, 16'h0003, 32'h00000001},
        {4'd12, 32'h00000002, 16'h0003, 16'h0000, 16'h0002, 32'h00000000},
        {4'd13, 32'h00000000, 16'h0077, 16'h0077, 16'h0002, 32'h00000001},
        {4'd14, 32'h00000005, 16'h0000, 16'h0000, 16'h0006, 32'h00000000},
        {4'd15, 32'h00000055, 16'h0055, 16'h0000, 16'h0002, 32'h00000001}
    };

    function automatic logic [51:0] mk(input logic [3:0] op, input logic [15:0] a,
                                       input logic [15:0] b, input logic [15:0] c);
        return {op, a, b, c};
    endfunction

    function automatic logic [31:0] rg(input int i);
        return regs_flat[i*32 +: 32];
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd3) return "R7";
        if (op <= 4'd7) return "R8";
        if (op <= 4'd9) return "R9";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input int addr, input logic [51:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = 6'(addr); prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic configure(input logic [2:0] b, input logic [6:0] len);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bind = b; cfg_len = len;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input logic [31:0] seed);
        @(negedge clk);
        seed_r0 = seed; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected halt");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [191:0] snap;
        logic [3:0]   snap_steps;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", {31'd0, halted}, 32'd0);
        check("R1", {28'd0, steps}, 32'd0);
        for (int i = 0; i < 6; i++) check("R1", rg(i), 32'd0);

        // sample program, register 0 bound
        load(0, mk(4'd9, 16'd5, 16'd0, 16'd1));
        load(1, mk(4'd9, 16'd6, 16'd0, 16'd2));
        load(2, mk(4'd1, 16'd0, 16'd1, 16'd0));
        load(3, mk(4'd0, 16'd1, 16'd2, 16'd3));
        load(4, mk(4'd8, 16'd1, 16'd0, 16'd0));
        load(5, mk(4'd9, 16'd8, 16'd0, 16'd4));
        load(6, mk(4'd9, 16'd9, 16'd0, 16'd5));
        configure(3'd0, 7'd7);
        repeat (10) @(negedge clk);
        // R1: nothing runs before start
        check("R1", {31'd0, halted}, 32'd0);
        check("R1", rg(1), 32'd0);

        pulse_start(32'd0);
        check("R2", {31'd0, halted}, 32'd0);
        wait_halt();
        // R3: pointer copy-in / copy-back with increment
        check("R4", {31'd0, halted}, 32'd1);
        check("R3", rg(0), 32'd6);
        check("R3", rg(1), 32'd5);
        check("R3", rg(2), 32'd6);
        check("R3", rg(3), 32'd0);
        check("R3", rg(4), 32'd0);
        check("R3", rg(5), 32'd9);
        check("R3", {28'd0, steps}, 32'd5);

        // R5: frozen while halted
        snap = regs_flat; snap_steps = steps;
        repeat (20) @(negedge clk);
        check("R5", {31'd0, (regs_flat == snap)}, 32'd1);
        check("R5", {28'd0, steps}, {28'd0, snap_steps});
        check("R4", {31'd0, halted}, 32'd1);

        // R4 / R2: zero length halts at once; restart clears and seeds
        configure(3'd0, 7'd0);
        pulse_start(32'd3);
        wait_halt();
        check("R4", {31'd0, halted}, 32'd1);
        check("R4", {28'd0, steps}, 32'd0);
        check("R2", rg(0), 32'd3);
        check("R2", rg(1), 32'd0);
        check("R2", rg(5), 32'd0);

        // R6: index 6 reads zero, writes to index 7 dropped
        load(0, mk(4'd9, 16'h0022, 16'd0, 16'd1));
        load(1, mk(4'd8, 16'd6, 16'd0, 16'd1));
        load(2, mk(4'd9, 16'h0033, 16'd0, 16'd7));
        configure(3'd5, 7'd3);
        pulse_start(32'd0);
        wait_halt();
        check("R6", rg(1), 32'd0);
        for (int i = 0; i < 5; i++) check("R6", rg(i), 32'd0);
        check("R6", rg(5), 32'd2);
        check("R6", {28'd0, steps}, 32'd3);

        // R7..R10: operation table
        configure(3'd5, 7'd2);
        for (int v = 0; v < NV; v++) begin
            logic [115:0] e;
            e = VEC[v];
            load(0, mk(4'd9, e[79:64], 16'd0, 16'd2));
            load(1, mk(e[115:112], e[63:48], e[47:32], 16'd3));
            pulse_start(e[111:80]);
            wait_halt();
            check(tag_of(e[115:112]), rg(3), e[31:0]);
            check("R6", {28'd0, steps}, 32'd2);
        end

        // R11 / R12: 20-step loop with register 3 bound, restart attempt mid-run
        load(0, mk(4'd9, 16'd0, 16'd0, 16'd1));
        load(1, mk(4'd1, 16'd1, 16'd1, 16'd1));
        load(2, mk(4'd11, 16'd1, 16'd4, 16'd2));
        load(3, mk(4'd0, 16'd3, 16'd2, 16'd3));
        load(4, mk(4'd9, 16'd0, 16'd0, 16'd3));
        configure(3'd3, 7'd5);
        pulse_start(32'd7);
        repeat (10) @(negedge clk);
        pulse_start(32'd9);
        wait_halt();
        check("R12", rg(0), 32'd7);
        check("R12", rg(1), 32'd5);
        check("R12", rg(2), 32'd1);
        check("R3", rg(3), 32'd4);
        check("R11", {28'd0, steps}, 32'd15);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule